// File: doc/BRIEF.md
# Digit-Serial Gaussian Normal Basis Multiplier

This block multiplies two elements of GF(2^m) held in a Gaussian normal basis of type T. Operand bit i is the coefficient of beta^(2^i), where beta is the normal element. A host drives both operands and raises `start` for one cycle while the block is idle. The block then computes DIGIT product coefficients per clock. After q = ceil(m/DIGIT) working cycles it raises `done` for one cycle, and the full product is on `product`.

Each working cycle rotates both operand registers and the accumulator by DIGIT positions. The DIGIT freshly computed coefficients are XORed into fixed accumulator positions. In the final cycle, a control line switches off the partial terms whose coefficient index would pass m-1. Those terms only exist when DIGIT does not divide m. The multiplication matrix is derived from m and T at elaboration. The default configuration is m = 7, T = 4 (p = 29), DIGIT = 2. DIGIT = 1 and DIGIT = 7 trade cycles for area at either end of the range.

Top module: `gnb_mul`

## Requirements
- R1: Bit l of `product` equals the XOR over k = 1..p-2 of a[(F(k+1)+l) mod m] AND b[(F(p-k)+l) mod m]. Here p = mT+1, u has multiplicative order T mod p, and F(2^i·u^j mod p) = i for 0 <= i < m and 0 <= j < T. This holds for every DIGIT, including a DIGIT that does not divide m.
- R2: `done` goes high exactly q = ceil(m/DIGIT) clock edges after the edge that accepts `start`, and `busy` is high for all cycles in between. For m = 7 the values are q = 4, 7 and 1 for DIGIT = 2, 1 and 7.
- R3: `done` is high for a single cycle per operation, and `busy` is low whenever `done` is high.
- R4: A `start` sampled while `busy` is high is ignored. The running product and its `done` cycle are unchanged, even if the operand inputs change.
- R5: A `start` sampled in the cycle in which `done` is high is accepted. The new product follows q edges later.
- R6: While the block is idle and `start` is low, `product` keeps its value.
- R7: After reset, `busy`, `done` and `product` are all zero.
- R8: The all-ones word, which is the field's unit, times any b gives b. A zero operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; accepted only when idle |
| op_a | input | M_W | First operand, normal-basis coefficients |
| op_b | input | M_W | Second operand, normal-basis coefficients |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse; product valid |
| product | output | M_W | Normal-basis product, held until the next accepted start |

## Verification
Two events can fall in the same cycle: the completion pulse of one product and the acceptance of the next `start`. The bench provokes this by raising `start` with new operands in exactly the cycle where `done` is seen. It then requires the old product to be visible in that cycle and the new product to arrive q edges later. It also raises `start` with different operands in the middle of a running operation and requires an unchanged result on the original schedule. Results from all three digit widths are compared against a direct evaluation of the coefficient formula, using random, zero and all-ones operands.

// File: rtl/gnb_pkg.sv
package gnb_pkg;

    // Smallest element of multiplicative order exactly t modulo p = m*t+1.
    function automatic int gnb_unit(input int m, input int t);
        int  p;
        int  res;
        int  acc;
        logic ok;
        p   = m * t + 1;
        res = 1;
        for (int c = p - 1; c >= 2; c--) begin
            acc = 1;
            ok  = 1'b1;
            for (int e = 1; e <= t; e++) begin
                acc = (acc * c) % p;
                if (e < t && acc == 1) ok = 1'b0;
            end
            if (acc != 1) ok = 1'b0;
            if (ok) res = c;
        end
        return res;
    endfunction

    // Exponent i such that x = 2^i * u^j mod p for some j.
    function automatic int gnb_log(input int x, input int m, input int t, input int u);
        int p;
        int res;
        int pw;
        int uj;
        p   = m * t + 1;
        res = 0;
        pw  = 1;
        for (int i = 0; i < m; i++) begin
            uj = pw;
            for (int j = 0; j < t; j++) begin
                if (uj == x) res = i;
                uj = (uj * u) % p;
            end
            pw = (pw * 2) % p;
        end
        return res;
    endfunction

    // Row r of the multiplication matrix (m <= 32).
    function automatic logic [31:0] gnb_row(input int m, input int t, input int r);
        int          p;
        int          u;
        int          col;
        logic [31:0] row;
        p   = m * t + 1;
        u   = gnb_unit(m, t);
        row = '0;
        for (int k = 1; k <= p - 2; k++) begin
            if (gnb_log(k + 1, m, t, u) == r) begin
                col      = gnb_log(p - k, m, t, u);
                row[col] = ~row[col];
            end
        end
        return row;
    endfunction

endpackage

// File: rtl/gnb_term.sv
module gnb_term #(
    parameter int M_W   = 7,
    parameter int GNB_T = 4
) (
    input  logic [M_W-1:0] u_i,
    input  logic [M_W-1:0] v_i,
    output logic           bit_o
);
    logic [M_W-1:0] row_hit;

    for (genvar r = 0; r < M_W; r++) begin : g_row
        localparam logic [31:0] ROW = gnb_pkg::gnb_row(M_W, GNB_T, r);
        assign row_hit[r] = u_i[r] & (^(v_i & ROW[M_W-1:0]));
    end

    assign bit_o = ^row_hit;
endmodule

// File: rtl/gnb_digit_sum.sv
module gnb_digit_sum #(
    parameter int M_W   = 7,
    parameter int DIGIT = 2,
    parameter int GNB_T = 4
) (
    input  logic [M_W-1:0] x_i,
    input  logic [M_W-1:0] y_i,
    input  logic           last_i,
    output logic [M_W-1:0] lsum_o
);
    localparam int Q    = (M_W + DIGIT - 1) / DIGIT;
    localparam int REM  = M_W - DIGIT * (Q - 1);
    localparam int BASE = (DIGIT * (Q - 1)) % M_W;

    logic [DIGIT-1:0] term;
    logic [DIGIT-1:0] term_g;
    logic             reg_en;

    // Low only in the final cycle: disables terms past coefficient m-1.
    assign reg_en = ~last_i;

    for (genvar t = 0; t < DIGIT; t++) begin : g_term
        localparam logic KEEP = (t < REM);
        logic [M_W-1:0] u_t;
        logic [M_W-1:0] v_t;

        always_comb begin
            for (int i = 0; i < M_W; i++) begin
                u_t[i] = x_i[(i + t) % M_W];
                v_t[i] = y_i[(i + t) % M_W];
            end
        end

        gnb_term #(.M_W(M_W), .GNB_T(GNB_T)) u_term (
            .u_i  (u_t),
            .v_i  (v_t),
            .bit_o(term[t])
        );

        assign term_g[t] = term[t] & (reg_en | KEEP);
    end

    always_comb begin
        lsum_o = '0;
        for (int t2 = 0; t2 < DIGIT; t2++) begin
            lsum_o[(t2 + BASE) % M_W] = term_g[t2];
        end
    end
endmodule

// File: rtl/gnb_mul.sv
module gnb_mul #(
    parameter int M_W   = 7,
    parameter int DIGIT = 2,
    parameter int GNB_T = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [M_W-1:0] op_a,
    input  logic [M_W-1:0] op_b,
    output logic           busy,
    output logic           done,
    output logic [M_W-1:0] product
);
    localparam int Q  = (M_W + DIGIT - 1) / DIGIT;
    localparam int CW = (Q > 1) ? $clog2(Q) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(Q - 1);

    typedef struct packed {
        logic [M_W-1:0] x;
        logic [M_W-1:0] y;
        logic [M_W-1:0] z;
        logic [CW-1:0]  cnt;
        logic           busy;
        logic           done;
    } state_t;

    state_t         st_d;
    state_t         st_q;
    logic           last_cyc;
    logic [M_W-1:0] lsum;

    assign last_cyc = st_q.busy && (st_q.cnt == LAST_IDX);

    gnb_digit_sum #(.M_W(M_W), .DIGIT(DIGIT), .GNB_T(GNB_T)) u_lsum (
        .x_i   (st_q.x),
        .y_i   (st_q.y),
        .last_i(last_cyc),
        .lsum_o(lsum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            for (int i = 0; i < M_W; i++) begin
                st_d.x[i] = st_q.x[(i + DIGIT) % M_W];
                st_d.y[i] = st_q.y[(i + DIGIT) % M_W];
                st_d.z[i] = st_q.z[(i + DIGIT) % M_W] ^ lsum[i];
            end
            st_d.cnt = st_q.cnt + 1'b1;
            if (last_cyc) begin
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            st_d.x    = op_a;
            st_d.y    = op_b;
            st_d.z    = '0;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign product = st_q.z;
endmodule

// File: rtl/gnb_mul_chk.sv
module gnb_mul_chk #(
    parameter int M_W = 7,
    parameter int Q   = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [M_W-1:0] product
);
    localparam int LW = $clog2(Q + 2);
    logic [LW-1:0] lat_q;

    // Edges since the accepting edge; an ignored start does not clear it (R4).
    always_ff @(posedge clk) begin
        if (rst)                 lat_q <= '0;
        else if (start && !busy) lat_q <= '0;
        else if (busy)           lat_q <= lat_q + 1'b1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == LW'(Q)));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind gnb_mul gnb_mul_chk #(.M_W(M_W), .Q(Q)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .product(product)
);

// File: tb/gnb_mul_tb.sv
`timescale 1ns/1ps
module gnb_mul_tb;
    localparam int MW = 7;
    localparam int TT = 4;
    localparam int PP = MW * TT + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    st  = '0;
    logic [MW-1:0] opa = '0;
    logic [MW-1:0] opb = '0;
    logic [2:0]    bz;
    logic [2:0]    dn;
    logic [MW-1:0] pr [3];
    int            qv [3] = '{4, 7, 1};
    int            nchk = 0;
    int            nfail = 0;
    int            ftab [PP];

    always #10 clk = ~clk;

    gnb_mul #(.M_W(MW), .DIGIT(2), .GNB_T(TT)) u_dut (
        .clk(clk), .rst(rst), .start(st[0]), .op_a(opa), .op_b(opb),
        .busy(bz[0]), .done(dn[0]), .product(pr[0]));
    gnb_mul #(.M_W(MW), .DIGIT(1), .GNB_T(TT)) u_dut1 (
        .clk(clk), .rst(rst), .start(st[1]), .op_a(opa), .op_b(opb),
        .busy(bz[1]), .done(dn[1]), .product(pr[1]));
    gnb_mul #(.M_W(MW), .DIGIT(7), .GNB_T(TT)) u_dut7 (
        .clk(clk), .rst(rst), .start(st[2]), .op_a(opa), .op_b(opb),
        .busy(bz[2]), .done(dn[2]), .product(pr[2]));

    function automatic logic [MW-1:0] ref_mul(input logic [MW-1:0] a, input logic [MW-1:0] b);
        logic [MW-1:0] c;
        logic          acc;
        for (int l = 0; l < MW; l++) begin
            acc = 1'b0;
            for (int k = 1; k <= PP - 2; k++)
                acc ^= a[(ftab[k+1] + l) % MW] & b[(ftab[PP-k] + l) % MW];
            c[l] = acc;
        end
        return c;
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [MW-1:0] a, input logic [MW-1:0] b,
                          input logic [2:0] mask, input int poke);
        logic [MW-1:0] e;
        e = ref_mul(a, b);
        @(negedge clk);
        opa = a; opb = b; st = mask;
        for (int c = 1; c <= 9; c++) begin
            @(negedge clk);
            st = '0;
            if (c == poke) begin
                opa = ~a; opb = a ^ b; st = mask & 3'b011;
            end
            for (int k = 0; k < 3; k++) begin
                if (mask[k]) begin
                    if (c == qv[k] + 1) begin
                        chk(dn[k] == 1'b1, "R2 done latency", MW'(dn[k]), MW'(1));
                        chk(pr[k] == e, (poke != 0) ? "R4 ignored start product" : "R1 product",
                            pr[k], e);
                    end else begin
                        chk(dn[k] == 1'b0, "R3 single done", MW'(dn[k]), MW'(0));
                    end
                    if (c <= qv[k]) chk(bz[k] == 1'b1, "R2 busy", MW'(bz[k]), MW'(1));
                end
            end
        end
    endtask

    task automatic b2b(input int k, input logic [MW-1:0] a, input logic [MW-1:0] b,
                       input logic [MW-1:0] a2, input logic [MW-1:0] b2);
        logic [MW-1:0] e1;
        logic [MW-1:0] e2;
        e1 = ref_mul(a, b);
        e2 = ref_mul(a2, b2);
        @(negedge clk);
        opa = a; opb = b; st = 3'(1 << k);
        for (int c = 1; c <= 2 * qv[k] + 3; c++) begin
            @(negedge clk);
            st = '0;
            if (c == qv[k] + 1) begin
                chk(dn[k] == 1'b1, "R5 first done", MW'(dn[k]), MW'(1));
                chk(pr[k] == e1, "R5 first product", pr[k], e1);
                chk(bz[k] == 1'b0, "R3 idle at done", MW'(bz[k]), MW'(0));
                opa = a2; opb = b2; st[k] = 1'b1;
            end
            if (c == 2 * qv[k] + 2) begin
                chk(dn[k] == 1'b1, "R5 second done", MW'(dn[k]), MW'(1));
                chk(pr[k] == e2, "R5 second product", pr[k], e2);
            end
        end
    endtask

    task automatic hold_check();
        logic [MW-1:0] pv [3];
        for (int k = 0; k < 3; k++) pv[k] = pr[k];
        opa = ~opa; opb = ~opb;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) chk(pr[k] == pv[k], "R6 idle hold", pr[k], pv[k]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", MW'(0), MW'(1));
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int            u;
        int            pw;
        int            uj;
        logic [MW-1:0] x;
        logic [MW-1:0] y;
        u = 0;
        for (int c = 2; c < PP; c++) begin
            int acc;
            acc = 1;
            for (int e = 1; e <= TT; e++) begin
                acc = (acc * c) % PP;
                if (e < TT && acc == 1) acc = -1;
                if (acc < 0) break;
            end
            if (acc == 1 && u == 0) u = c;
        end
        pw = 1;
        for (int i = 0; i < MW; i++) begin
            uj = pw;
            for (int j = 0; j < TT; j++) begin
                ftab[uj] = i;
                uj = (uj * u) % PP;
            end
            pw = (pw * 2) % PP;
        end
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(bz[k] == 1'b0, "R7 reset busy", MW'(bz[k]), MW'(0));
            chk(dn[k] == 1'b0, "R7 reset done", MW'(dn[k]), MW'(0));
            chk(pr[k] == '0, "R7 reset product", pr[k], MW'(0));
        end
        rst = 1'b0;

        x = MW'($urandom());
        run_op('0, x, 3'b111, 0);
        for (int k = 0; k < 3; k++) chk(pr[k] == '0, "R8 zero operand", pr[k], MW'(0));
        run_op({MW{1'b1}}, x, 3'b111, 0);
        for (int k = 0; k < 3; k++) chk(pr[k] == x, "R8 unit left", pr[k], x);
        y = MW'($urandom());
        run_op(y, {MW{1'b1}}, 3'b111, 0);
        for (int k = 0; k < 3; k++) chk(pr[k] == y, "R8 unit right", pr[k], y);
        run_op({MW{1'b1}}, {MW{1'b1}}, 3'b111, 0);
        hold_check();

        for (int n = 0; n < 40; n++) begin
            x = MW'($urandom());
            y = MW'($urandom());
            run_op(x, y, 3'b111, 0);
        end
        hold_check();

        for (int n = 0; n < 4; n++) begin
            x = MW'($urandom());
            y = MW'($urandom());
            run_op(x, y, 3'b011, 2);
        end

        for (int k = 0; k < 3; k++) begin
            b2b(k, MW'($urandom()), MW'($urandom()), MW'($urandom()), MW'($urandom()));
            repeat (2) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule